// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter that serves up to eight multiplexed inputs. Software uses a small register bus. It writes a control word at address 0 and reads a result word at address 1. The block divides the bus clock down to a conversion clock. During a conversion it drives a one-hot input-select vector and a trial code to an external DAC. On each conversion-clock tick it samples a single comparator bit, which is 1 when the selected input is at or above the trial code. It then keeps or clears the bit under test.

There are two ways to start conversions. A one-shot start converts the lowest enabled input once. A scan mode converts the enabled inputs in a loop. The resolution can be reduced one bit at a time, and each bit removed saves one conversion-clock period.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The control word (address 0) reads back exactly as written. Its fields are: input enables in bits [7:0] (bit i enables input i), divisor in [15:8], scan enable in bit 16, resolution code in [19:17], power enable in bit 21 and start code in [26:24]. The control word and the result word both read 0 after reset.
- R2: The conversion clock is the bus clock divided by (divisor + 1). A conversion of N bits sets DONE exactly (N+1)·(divisor+1) bus-clock cycles after the edge that accepts the start.
- R3: The resolution code k gives N = 10 − k result bits. The result is left-justified in the 10-bit field, with the unconverted low bits zero, so it equals the input value with its low k bits cleared.
- R4: Writing start code 001 with power enable 1 and scan enable 0 converts the lowest enabled input once. The result word then holds DONE in bit 31, the input number in [26:24] and the result in [15:6].
- R5: While power enable is 0, start writes are ignored and the select and trial outputs stay 0. Clearing power enable stops a running conversion at once.
- R6: With scan enable 1 and start code 000, the enabled inputs are converted one after another in ascending index order, wrapping back to the lowest.
- R7: With scan enable 1 and a nonzero start code, no conversion begins.
- R8: Reading the result word clears DONE.
- R9: During a conversion the select output is one-hot on the input being converted. When idle, the select output and the trial code are both 0.
- R10: A start write with no input enabled begins no conversion.
- R11: In scan mode with a single enabled input, that input is converted repeatedly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (clears DONE when reading address 1) |
| bus_addr | input | 1 | 0 = control word, 1 = result word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial code |
| ch_sel | output | NUM_CH | One-hot input select |
| dac_code | output | RES_MAX | Trial code to the DAC |

## Verification
The bench builds the block with its default parameters: eight inputs and a 10-bit result. This makes every start-code, scan-enable and resolution-code combination reachable, and it lets the scan order wrap across non-adjacent enabled inputs. The divisor is a register field rather than a parameter, so divisors 0, 1 and 2 are set at run time. This allows exact cycle counts to be compared against (N+1)·(divisor+1) for full and reduced resolution.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int SEL_LSB   = 0;
   localparam int DIV_LSB   = 8;
   localparam int SCAN_BIT  = 16;
   localparam int RES_LSB   = 17;
   localparam int PWR_BIT   = 21;
   localparam int GO_LSB    = 24;
   localparam int DONE_BIT  = 31;
   localparam int CHN_LSB   = 24;
   localparam int RES_TOP   = 15;
   localparam logic [2:0] GO_ONCE = 3'b001;

   typedef enum logic [1:0] {
      CS_IDLE   = 2'd0,
      CS_SAMPLE = 2'd1,
      CS_TRIAL  = 2'd2
   } conv_st_e;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R2: with a nonzero divisor, ticks are never back to back
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/sar_chan_pick.sv
module sar_chan_pick #(
   parameter int NUM_CH = 8,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] sel,
   input  logic [CH_W-1:0]   last,
   output logic [CH_W-1:0]   first,
   output logic [CH_W-1:0]   nxt,
   output logic              any
);
   logic found_f, found_n;

   always_comb begin
      first   = '0;
      nxt     = '0;
      found_f = 1'b0;
      found_n = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (sel[i] && !found_f) begin
            first   = CH_W'(i);
            found_f = 1'b1;
         end
         if (sel[i] && !found_n && (i > int'(last))) begin
            nxt     = CH_W'(i);
            found_n = 1'b1;
         end
      end
      if (!found_n) nxt = first;
   end

   assign any = |sel;
endmodule

// File: rtl/sar_core.sv
module sar_core
   import sar_pkg::*;
#(
   parameter int RES_MAX = 10,
   localparam int POS_W = $clog2(RES_MAX),
   localparam int CNT_W = $clog2(RES_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               abort,
   input  logic               tick,
   input  logic [CNT_W-1:0]   nbits,
   input  logic               cmp,
   output logic               busy,
   output logic [RES_MAX-1:0] code,
   output logic               fin,
   output logic [RES_MAX-1:0] result
);
   conv_st_e           st_q;
   logic [RES_MAX-1:0] code_q, trial;
   logic [POS_W-1:0]   pos_q;
   logic [CNT_W-1:0]   left_q;

   assign busy = (st_q != CS_IDLE);
   assign code = code_q;

   always_comb begin
      trial = code_q;
      if (!cmp) trial[pos_q] = 1'b0;
      if (left_q > CNT_W'(1)) trial[pos_q - POS_W'(1)] = 1'b1;
   end

   assign fin    = (st_q == CS_TRIAL) && tick && !abort && (left_q == CNT_W'(1));
   assign result = trial;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CS_IDLE;
         code_q <= '0;
         pos_q  <= '0;
         left_q <= '0;
      end else if (abort) begin
         st_q   <= CS_IDLE;
         code_q <= '0;
      end else begin
         unique case (st_q)
            CS_IDLE: if (start) begin
               st_q   <= CS_SAMPLE;
               code_q <= '0;
            end
            CS_SAMPLE: if (tick) begin
               code_q              <= '0;
               code_q[RES_MAX-1]   <= 1'b1;
               pos_q               <= POS_W'(RES_MAX - 1);
               left_q              <= nbits;
               st_q                <= CS_TRIAL;
            end
            CS_TRIAL: if (tick) begin
               if (fin) begin
                  st_q   <= CS_IDLE;
                  code_q <= '0;
               end else begin
                  code_q <= trial;
                  pos_q  <= pos_q - POS_W'(1);
                  left_q <= left_q - CNT_W'(1);
               end
            end
            default: st_q <= CS_IDLE;
         endcase
      end
   end

   // R2: the trial code only moves on a conversion-clock tick
   p_code_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CS_TRIAL && !tick && !abort) |=> $stable(code_q));
   // R9: the trial code is zero once the engine is idle
   p_idle_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fin || abort) |=> (code_q == '0));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
   import sar_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int RES_MAX = 10,
   parameter int DIV_W   = 8,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int CNT_W  = $clog2(RES_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic               bus_re,
   input  logic               bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               cmp_in,
   output logic [NUM_CH-1:0]  ch_sel,
   output logic [RES_MAX-1:0] dac_code
);
   if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_ch
      $error("NUM_CH must lie in 2..8");
   end
   if (RES_MAX < 8 || RES_MAX > 16) begin : g_bad_res
      $error("RES_MAX must lie in 8..16");
   end
   if (DIV_W != 8) begin : g_bad_div
      $error("DIV_W must be 8 to fit the divisor field");
   end

   logic [31:0]        ctrl_q;
   logic               done_q;
   logic [RES_MAX-1:0] res_q;
   logic [CH_W-1:0]    dch_q, cur_ch_q, last_ch_q;

   logic               wr_ctrl, rd_data;
   logic [NUM_CH-1:0]  sel_now, pick_sel;
   logic [DIV_W-1:0]   div_v;
   logic               scan_on, pwr_on;
   logic [2:0]         res_code, go_code;
   logic [CNT_W-1:0]   nbits;
   logic [CH_W-1:0]    pick_first, pick_next, start_ch;
   logic               pick_any;
   logic               busy, tick, fin, start, abort, once_go, scan_go;
   logic [RES_MAX-1:0] core_code, core_res;

   assign wr_ctrl  = bus_we && !bus_addr;
   assign rd_data  = bus_re && bus_addr;
   assign sel_now  = ctrl_q[SEL_LSB +: NUM_CH];
   assign div_v    = ctrl_q[DIV_LSB +: DIV_W];
   assign scan_on  = ctrl_q[SCAN_BIT];
   assign pwr_on   = ctrl_q[PWR_BIT];
   assign res_code = ctrl_q[RES_LSB +: 3];
   assign go_code  = ctrl_q[GO_LSB +: 3];
   assign nbits    = CNT_W'(RES_MAX) - CNT_W'(res_code);

   assign pick_sel = wr_ctrl ? bus_wdata[SEL_LSB +: NUM_CH] : sel_now;

   sar_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
      .sel   (pick_sel),
      .last  (last_ch_q),
      .first (pick_first),
      .nxt   (pick_next),
      .any   (pick_any)
   );

   assign once_go = wr_ctrl && !busy && bus_wdata[PWR_BIT] && !bus_wdata[SCAN_BIT]
                    && (bus_wdata[GO_LSB +: 3] == GO_ONCE) && pick_any;
   assign scan_go = !wr_ctrl && !busy && scan_on && pwr_on
                    && (go_code == 3'b000) && pick_any;
   assign start    = once_go || scan_go;
   assign start_ch = once_go ? pick_first : pick_next;
   assign abort    = wr_ctrl && !bus_wdata[PWR_BIT];

   sar_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .div   (div_v),
      .tick  (tick)
   );

   sar_core #(.RES_MAX(RES_MAX)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .abort  (abort),
      .tick   (tick),
      .nbits  (nbits),
      .cmp    (cmp_in),
      .busy   (busy),
      .code   (core_code),
      .fin    (fin),
      .result (core_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         done_q    <= 1'b0;
         res_q     <= '0;
         dch_q     <= '0;
         cur_ch_q  <= '0;
         last_ch_q <= CH_W'(NUM_CH - 1);
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata;
         if (start) begin
            cur_ch_q  <= start_ch;
            last_ch_q <= start_ch;
         end else if (wr_ctrl) begin
            last_ch_q <= CH_W'(NUM_CH - 1);
         end
         if (fin) begin
            done_q <= 1'b1;
            res_q  <= core_res;
            dch_q  <= cur_ch_q;
         end else if (rd_data) begin
            done_q <= 1'b0;
         end
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
      assign ch_sel[g] = busy && (cur_ch_q == CH_W'(g));
   end
   assign dac_code = core_code;

   always_comb begin
      if (!bus_addr) begin
         bus_rdata = ctrl_q;
      end else begin
         bus_rdata = '0;
         bus_rdata[DONE_BIT] = done_q;
         bus_rdata[CHN_LSB +: CH_W] = dch_q;
         bus_rdata[RES_TOP-RES_MAX+1 +: RES_MAX] = res_q;
      end
   end

   // R5: with power off nothing is selected and no trial code is driven
   p_pwr_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |-> (ch_sel == '0 && dac_code == '0));
   // R7: scan enabled with a nonzero start code never leaves idle
   p_scan_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_on && go_code != 3'b000 && !busy && !wr_ctrl) |=> !busy);
   // R8: a read of the result word without a completion clears DONE
   p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !fin) |=> !done_q);
   // R9: at most one input selected, exactly one while converting
   p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_sel) && (busy == ($countones(ch_sel) == 1)));
endmodule

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
   localparam int NUM_CH  = 8;
   localparam int RES_MAX = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0, bus_re = 1'b0, bus_addr = 1'b1;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              cmp_in;
   logic [NUM_CH-1:0] ch_sel;
   logic [RES_MAX-1:0] dac_code;
   logic [RES_MAX-1:0] vin [NUM_CH];
   logic [RES_MAX-1:0] vsel;

   int n_chk = 0, n_fail = 0, cyc = 0;

   sar_adc_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cmp_in(cmp_in), .ch_sel(ch_sel), .dac_code(dac_code)
   );

   always #2 clk = ~clk;

   always_comb begin
      vsel = '0;
      for (int i = 0; i < NUM_CH; i++) if (ch_sel[i]) vsel = vin[i];
   end
   assign cmp_in = (vsel >= dac_code);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      bus_addr = 1'b0; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0; bus_addr = 1'b1;
   endtask

   task automatic rd_ctrl(output logic [31:0] d);
      bus_addr = 1'b0; #0.1; d = bus_rdata; bus_addr = 1'b1;
   endtask

   task automatic rd_clear(output logic [31:0] d);
      bus_addr = 1'b1; bus_re = 1'b1; #0.1; d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!bus_rdata[31] && n < 5000) begin
         @(posedge clk); @(negedge clk); n++;
      end
   endtask

   function automatic logic [31:0] word(input int ch, input logic [RES_MAX-1:0] r);
      return (32'h1 << 31) | (32'(ch) << 24) | (32'(r) << 6);
   endfunction

   task automatic idle_span(input string tag);
      int busy_seen = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (ch_sel != '0 || dac_code != '0 || bus_rdata[31]) busy_seen++;
      end
      chk(busy_seen == 0, tag, busy_seen, 0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd_ctrl(d);
      chk(d == 0, "R1 control after reset", d, 0);
      chk(bus_rdata == 0, "R1 result after reset", bus_rdata, 0);
      chk(ch_sel == 0 && dac_code == 0, "R9 idle outputs", {ch_sel, dac_code}, 0);
   endtask

   task automatic t_readback_pwr_off();
      logic [31:0] d;
      wr(32'h0716_3C5A);
      rd_ctrl(d);
      chk(d == 32'h0716_3C5A, "R1 control readback", d, 32'h0716_3C5A);
      wr(32'h0100_0004);
      idle_span("R5 start ignored with power off");
   endtask

   task automatic t_single(input int ch, input logic [7:0] sel, input int div,
                           input int k, input logic [RES_MAX-1:0] v);
      logic [31:0] d;
      int n;
      logic [RES_MAX-1:0] er;
      vin[ch] = v;
      er = v & ~((10'(1) << k) - 10'(1));
      wr(32'h0120_0000 | (32'(k) << 17) | (32'(div) << 8) | 32'(sel));
      chk(ch_sel == (8'(1) << ch), "R9 select during conversion", ch_sel, 8'(1) << ch);
      wait_done(n);
      chk(n == (RES_MAX - k + 1) * (div + 1), "R2 conversion cycles", n, (RES_MAX - k + 1) * (div + 1));
      rd_clear(d);
      chk(d == word(ch, er), k != 0 ? "R3 reduced result" : "R4 single result", d, word(ch, er));
      chk(ch_sel == 0 && dac_code == 0, "R9 idle after done", {ch_sel, dac_code}, 0);
   endtask

   task automatic t_read_clear();
      logic [31:0] d;
      vin[0] = 10'h0F0;
      wr(32'h0120_0001);
      wait_done(d);
      rd_clear(d);
      chk(d[31], "R8 done before read", d, 32'h8000_0000);
      rd_clear(d);
      chk(!d[31], "R8 done cleared by read", d, 0);
   endtask

   task automatic t_no_sel();
      wr(32'h0120_0000);
      idle_span("R10 start with no input enabled");
   endtask

   task automatic t_scan_blocked();
      wr(32'h0121_004A);
      idle_span("R7 scan with nonzero start code");
   endtask

   task automatic t_scan(input logic [7:0] sel, input int exp_ch [5], input string tag);
      logic [31:0] d;
      int n;
      wr(32'h0021_0000 | 32'(sel));
      for (int i = 0; i < 5; i++) begin
         wait_done(n);
         rd_clear(d);
         chk(d == word(exp_ch[i], vin[exp_ch[i]]), tag, d, word(exp_ch[i], vin[exp_ch[i]]));
      end
      wr(32'h0000_0000);
      chk(ch_sel == 0 && dac_code == 0, "R5 power off stops conversion", {ch_sel, dac_code}, 0);
      rd_clear(d);
      idle_span("R5 stays idle after power off");
   endtask

   initial begin
      int order_a [5] = '{1, 3, 6, 1, 3};
      int order_b [5] = '{5, 5, 5, 5, 5};
      for (int i = 0; i < NUM_CH; i++) vin[i] = '0;
      vin[1] = 10'h123; vin[3] = 10'h3FF; vin[6] = 10'h001; vin[5] = 10'h155;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback_pwr_off();
      t_single(2, 8'h04, 0, 0, 10'h2A5);
      t_single(4, 8'h30, 2, 0, 10'h19C);
      t_single(7, 8'h80, 1, 3, 10'h3FF);
      t_single(0, 8'h01, 1, 7, 10'h1B7);
      t_read_clear();
      t_no_sel();
      t_scan_blocked();
      vin[1] = 10'h123; vin[3] = 10'h3FF;
      t_scan(8'h4A, order_a, "R6 ascending scan with wrap");
      t_scan(8'h20, order_b, "R11 single input scan");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule